// File: doc/BRIEF.md
# Privileged Control Register Access Checker

This block rules on every read or write aimed at one 64-bit control register. The register can be reached under two names: a primary name and an alias. For each request it looks at the privilege level of the requester (0 to 3), whether the feature exists, the state of the second and third levels, a set of enable and trap bits taken from other control registers, and a 3-bit nested-virtualization mode. From these it settles exactly one outcome. The outcome is one of five: undefined instruction, a trap to a stated level with an 8-bit class code, redirection to a fixed memory slot, or an access to one of two register copies (copy 1 for the first level, copy 2 for the second).

The block holds both register copies itself. On a write it clears every bit that is not implemented. The response comes out one clock after the request, and a read returns the chosen copy in that same response. Taking the exception and carrying out the memory access are left to the pipeline around the block.

Top module: `ctlacc_gate`

## Requirements
- R1: When `feat_present` is 0 or `cur_lvl` is 0, the outcome is undefined, for both the primary name and the alias.
- R2: Primary name at level 1 takes the first checks in this order. If `l3_exists`, `l3_undef_first` and a 0 on `l3_enable` all hold, the outcome is undefined. Otherwise, if `l1_gate` is 0, the access traps to level 1 with class 0x1D.
- R3: Primary name at level 1, checked next. If `l2_enabled` is 1, `l2_host` is 0 and `l2_trap` is 1, the access traps to level 2 with class 0x1D. Otherwise, if `l2_host` is 1 and `l2_gate` is 0, it traps to level 2 with class 0x1D.
- R4: Primary name at level 1 or 2, checked next. If `l3_exists` is 1 and `l3_enable` is 0, the outcome depends on `l3_dbg_undef`: when it is 1 the outcome is undefined, and otherwise the access traps to level 3 with class 0x1D. When `l3_exists` is 0 this check is skipped.
- R5: Primary name at level 1, once it has passed all checks. A `nv_mode` of 3'b111 redirects the access to offset 0x1F0. Any other mode gives copy 1.
- R6: Primary name at level 2 runs the chain of R2 to R4 with three changes. The `l1_gate` check is dropped. The `l2_trap` check ignores `l2_enabled`. There is no redirect. The access ends at copy 2 when `l2_host` is 1 and at copy 1 otherwise.
- R7: Primary name at level 3 looks only at `l3_enable`. A 0 traps to level 3 with class 0x1D, and a 1 gives copy 1.
- R8: Alias at level 1. A `nv_mode` of 3'b101 redirects to 0x1F0. Otherwise, if bit 0 of `nv_mode` is 1, the access traps to level 2 with class 0x18. Otherwise the outcome is undefined.
- R9: Alias at level 2 or 3 is undefined when `l2_host` is 0. At level 2 in host mode, the checks are: the undefined-first rule of R2, then `l2_gate` at 0 trapping to level 2 with class 0x1D, then the rule of R4, and finally copy 1. At level 3 in host mode the rule of R7 applies.
- R10: A request is answered one cycle later with `rsp_valid` high and exactly one of the five outcome signals set. With no request, no outcome signal is set.
- R11: Writes keep only bits 3:0, bit 31 (if `HAS_OVR` is set) and bit 30 (if `HAS_TBL` is set). Every other bit reads back as 0. With the default parameters, writing all ones reads back as 0x8000000F.
- R12: A write changes only the copy that the outcome selects. A write whose outcome is undefined, trap or redirect leaves both copies unchanged. A read returns the selected copy on `rdata`, and `rdata` is 0 on any other response.
- R13: After reset both copies are 0 and `rsp_valid` with every outcome signal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_alias | input | 1 | 1 = alias name, 0 = primary name |
| cur_lvl | input | 2 | Current privilege level |
| feat_present | input | 1 | Feature implemented |
| l3_exists | input | 1 | Level 3 implemented |
| l2_enabled | input | 1 | Level 2 implemented and enabled |
| l2_host | input | 1 | Level 2 runs in host mode |
| l3_undef_first | input | 1 | Undefined takes priority over level-3 enable traps |
| l3_enable | input | 1 | Level-3 enable bit for this feature |
| l1_gate | input | 1 | Low bit of the level-1 enable field |
| l2_trap | input | 1 | Level-2 trap bit (non-host mode) |
| l2_gate | input | 1 | Low bit of the level-2 enable field (host mode) |
| l3_dbg_undef | input | 1 | Secure-debug rule turns the level-3 trap into undefined |
| nv_mode | input | 3 | Nested-virtualization mode |
| wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| out_undef | output | 1 | Outcome: undefined instruction |
| out_trap | output | 1 | Outcome: trap |
| trap_lvl | output | 2 | Trap target level (0 when not a trap) |
| trap_class | output | 8 | Trap class code (0 when not a trap) |
| out_redirect | output | 1 | Outcome: redirect to memory slot |
| redirect_off | output | 12 | Slot offset, 0x1F0 on redirect, else 0 |
| out_copy1 | output | 1 | Outcome: level-1 register copy |
| out_copy2 | output | 1 | Outcome: level-2 register copy |
| rdata | output | 64 | Read data of the selected copy |

## Verification
Each vector starts from a baseline in which every check passes, so the access reaches a register copy. It then breaks one condition, or two conditions that compete for priority. When two conditions are broken, the outcome shows which one the chain tests first. Examples are the undefined-first rule against the level-1 trap, and the level-2 trap bit with level 2 disabled. The same patterns are repeated with level 2, level 3 and the alias name. This separates the chains for each level and each name: a skipped check, a missing redirect, or a host-mode swap to copy 2 each change the outcome. Directed writes then store all ones, store to copy 2, and attempt writes that are trapped or redirected. The values read back show the bit masking and that a write reaches no copy other than the selected one.

// File: rtl/ctlacc_pkg.sv
`timescale 1ns/1ps
package ctlacc_pkg;

    typedef enum logic [2:0] {
        RES_UNDEF = 3'd0,
        RES_TRAP  = 3'd1,
        RES_REDIR = 3'd2,
        RES_COPY1 = 3'd3,
        RES_COPY2 = 3'd4
    } res_kind_t;

    typedef struct packed {
        res_kind_t  kind;
        logic [1:0] tlvl;
        logic [7:0] tclass;
    } verdict_t;

    typedef struct packed {
        logic       feat;
        logic       l3_exists;
        logic       l2_on;
        logic       l2_host;
        logic       l3_undef_first;
        logic       l3_allow;
        logic       l1_gate;
        logic       l2_trap;
        logic       l2_gate;
        logic       l3_dbg_undef;
        logic [2:0] nv;
    } ctx_t;

    localparam logic [7:0]  CLASS_ACCESS = 8'h1D;
    localparam logic [7:0]  CLASS_NVIRT  = 8'h18;
    localparam logic [11:0] NV_SLOT      = 12'h1F0;
    localparam int          OVR_POS      = 31;
    localparam int          TBL_POS      = 30;
    localparam int          NCOPY        = 2;

    function automatic verdict_t mk_res(input res_kind_t k);
        verdict_t v;
        v.kind   = k;
        v.tlvl   = 2'd0;
        v.tclass = 8'h00;
        return v;
    endfunction

    function automatic verdict_t mk_trap(input logic [1:0] lvl, input logic [7:0] cls);
        verdict_t v;
        v.kind   = RES_TRAP;
        v.tlvl   = lvl;
        v.tclass = cls;
        return v;
    endfunction

endpackage

// File: rtl/ctlacc_resolve.sv
`timescale 1ns/1ps
module ctlacc_resolve
    import ctlacc_pkg::*;
(
    input  logic       alias_sel,
    input  logic [1:0] lvl,
    input  ctx_t       c,
    output verdict_t   v
);
    logic     undef_first;
    logic     l3_block;
    verdict_t l3_res;

    always_comb begin
        undef_first = c.l3_exists && c.l3_undef_first && !c.l3_allow;
        l3_block    = c.l3_exists && !c.l3_allow;
        l3_res      = c.l3_dbg_undef ? mk_res(RES_UNDEF) : mk_trap(2'd3, CLASS_ACCESS);
        v           = mk_res(RES_UNDEF);

        if (!c.feat || lvl == 2'd0) begin
            v = mk_res(RES_UNDEF);
        end else if (!alias_sel) begin
            unique case (lvl)
                2'd1: begin
                    if (undef_first)                        v = mk_res(RES_UNDEF);
                    else if (!c.l1_gate)                    v = mk_trap(2'd1, CLASS_ACCESS);
                    else if (c.l2_on && !c.l2_host && c.l2_trap) v = mk_trap(2'd2, CLASS_ACCESS);
                    else if (c.l2_host && !c.l2_gate)       v = mk_trap(2'd2, CLASS_ACCESS);
                    else if (l3_block)                      v = l3_res;
                    else if (c.nv == 3'b111)                v = mk_res(RES_REDIR);
                    else                                    v = mk_res(RES_COPY1);
                end
                2'd2: begin
                    if (undef_first)                        v = mk_res(RES_UNDEF);
                    else if (!c.l2_host && c.l2_trap)       v = mk_trap(2'd2, CLASS_ACCESS);
                    else if (c.l2_host && !c.l2_gate)       v = mk_trap(2'd2, CLASS_ACCESS);
                    else if (l3_block)                      v = l3_res;
                    else if (c.l2_host)                     v = mk_res(RES_COPY2);
                    else                                    v = mk_res(RES_COPY1);
                end
                default: begin
                    if (!c.l3_allow)                        v = mk_trap(2'd3, CLASS_ACCESS);
                    else                                    v = mk_res(RES_COPY1);
                end
            endcase
        end else begin
            unique case (lvl)
                2'd1: begin
                    if (c.nv == 3'b101)                     v = mk_res(RES_REDIR);
                    else if (c.nv[0])                       v = mk_trap(2'd2, CLASS_NVIRT);
                    else                                    v = mk_res(RES_UNDEF);
                end
                2'd2: begin
                    if (!c.l2_host)                         v = mk_res(RES_UNDEF);
                    else if (undef_first)                   v = mk_res(RES_UNDEF);
                    else if (!c.l2_gate)                    v = mk_trap(2'd2, CLASS_ACCESS);
                    else if (l3_block)                      v = l3_res;
                    else                                    v = mk_res(RES_COPY1);
                end
                default: begin
                    if (!c.l2_host)                         v = mk_res(RES_UNDEF);
                    else if (!c.l3_allow)                   v = mk_trap(2'd3, CLASS_ACCESS);
                    else                                    v = mk_res(RES_COPY1);
                end
            endcase
        end
    end
endmodule

// File: rtl/ctlacc_store.sv
`timescale 1ns/1ps
module ctlacc_store #(
    parameter int               REG_W = 64,
    parameter int               NCOP  = 2,
    parameter logic [REG_W-1:0] KEEP  = '1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCOP-1:0]            wr_en,
    input  logic [REG_W-1:0]           wdata,
    output logic [NCOP-1:0][REG_W-1:0] copy_q
);
    for (genvar g = 0; g < NCOP; g++) begin : g_copy
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)           q <= '0;
            else if (wr_en[g]) q <= wdata & KEEP;
        end
        assign copy_q[g] = q;
    end
endmodule

// File: rtl/ctlacc_gate.sv
`timescale 1ns/1ps
module ctlacc_gate
    import ctlacc_pkg::*;
#(
    parameter int REG_W   = 64,
    parameter int LEN_W   = 4,
    parameter bit HAS_OVR = 1'b1,
    parameter bit HAS_TBL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_alias,
    input  logic [1:0]       cur_lvl,
    input  logic             feat_present,
    input  logic             l3_exists,
    input  logic             l2_enabled,
    input  logic             l2_host,
    input  logic             l3_undef_first,
    input  logic             l3_enable,
    input  logic             l1_gate,
    input  logic             l2_trap,
    input  logic             l2_gate,
    input  logic             l3_dbg_undef,
    input  logic [2:0]       nv_mode,
    input  logic [REG_W-1:0] wdata,
    output logic             rsp_valid,
    output logic             out_undef,
    output logic             out_trap,
    output logic [1:0]       trap_lvl,
    output logic [7:0]       trap_class,
    output logic             out_redirect,
    output logic [11:0]      redirect_off,
    output logic             out_copy1,
    output logic             out_copy2,
    output logic [REG_W-1:0] rdata
);
    localparam logic [REG_W-1:0] LEN_MASK = {{(REG_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};
    localparam logic [REG_W-1:0] KEEP = LEN_MASK
                                      | (REG_W'(HAS_OVR) << OVR_POS)
                                      | (REG_W'(HAS_TBL) << TBL_POS);

    ctx_t     ctx;
    verdict_t verdict;
    verdict_t verdict_q;
    logic     valid_q;
    logic [REG_W-1:0] rdata_q;
    logic [NCOPY-1:0] wr_en;
    logic [NCOPY-1:0][REG_W-1:0] copies;
    logic     is_copy;
    logic     sel;

    always_comb begin
        ctx.feat           = feat_present;
        ctx.l3_exists      = l3_exists;
        ctx.l2_on          = l2_enabled;
        ctx.l2_host        = l2_host;
        ctx.l3_undef_first = l3_undef_first;
        ctx.l3_allow       = l3_enable;
        ctx.l1_gate        = l1_gate;
        ctx.l2_trap        = l2_trap;
        ctx.l2_gate        = l2_gate;
        ctx.l3_dbg_undef   = l3_dbg_undef;
        ctx.nv             = nv_mode;
    end

    ctlacc_resolve u_resolve (
        .alias_sel (req_alias),
        .lvl       (cur_lvl),
        .c         (ctx),
        .v         (verdict)
    );

    always_comb begin
        is_copy  = (verdict.kind == RES_COPY1) || (verdict.kind == RES_COPY2);
        sel      = (verdict.kind == RES_COPY2);
        wr_en[0] = req_valid && req_write && (verdict.kind == RES_COPY1);
        wr_en[1] = req_valid && req_write && (verdict.kind == RES_COPY2);
    end

    ctlacc_store #(.REG_W(REG_W), .NCOP(NCOPY), .KEEP(KEEP)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .copy_q (copies)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= mk_res(RES_UNDEF);
            rdata_q   <= '0;
        end else begin
            valid_q   <= req_valid;
            verdict_q <= verdict;
            rdata_q   <= (req_valid && !req_write && is_copy) ? copies[sel] : '0;
        end
    end

    always_comb begin
        rsp_valid    = valid_q;
        out_undef    = valid_q && (verdict_q.kind == RES_UNDEF);
        out_trap     = valid_q && (verdict_q.kind == RES_TRAP);
        out_redirect = valid_q && (verdict_q.kind == RES_REDIR);
        out_copy1    = valid_q && (verdict_q.kind == RES_COPY1);
        out_copy2    = valid_q && (verdict_q.kind == RES_COPY2);
        trap_lvl     = out_trap ? verdict_q.tlvl : 2'd0;
        trap_class   = out_trap ? verdict_q.tclass : 8'h00;
        redirect_off = out_redirect ? NV_SLOT : 12'h000;
        rdata        = valid_q ? rdata_q : '0;
    end
endmodule

// File: rtl/ctlacc_gate_chk.sv
`timescale 1ns/1ps
module ctlacc_gate_chk #(
    parameter int REG_W   = 64,
    parameter int LEN_W   = 4,
    parameter bit HAS_OVR = 1'b1,
    parameter bit HAS_TBL = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_alias,
    input logic [1:0]       cur_lvl,
    input logic             feat_present,
    input logic             l3_enable,
    input logic             rsp_valid,
    input logic             out_undef,
    input logic             out_trap,
    input logic             out_redirect,
    input logic             out_copy1,
    input logic             out_copy2,
    input logic [11:0]      redirect_off,
    input logic [REG_W-1:0] rdata
);
    localparam logic [REG_W-1:0] KEEP_C = {{(REG_W-LEN_W){1'b0}}, {LEN_W{1'b1}}}
                                        | (REG_W'(HAS_OVR) << 31)
                                        | (REG_W'(HAS_TBL) << 30);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({out_undef, out_trap, out_redirect, out_copy1, out_copy2}) == 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $countones({out_undef, out_trap, out_redirect, out_copy1, out_copy2}) == 0);

    // R10
    answer_next_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R1
    early_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!feat_present || cur_lvl == 2'd0)) |=> out_undef);

    // R11
    masked_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rdata & ~KEEP_C) == '0);

    // R5
    slot_offset_chk: assert property (@(posedge clk) disable iff (rst)
        out_redirect |-> redirect_off == 12'h1F0);

    // R7
    top_level_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && feat_present && !req_alias && cur_lvl == 2'd3 && l3_enable) |=> out_copy1);
endmodule

bind ctlacc_gate ctlacc_gate_chk #(
    .REG_W(REG_W), .LEN_W(LEN_W), .HAS_OVR(HAS_OVR), .HAS_TBL(HAS_TBL)
) u_chk (.*);

// File: tb/tb_ctlacc_gate.sv
`timescale 1ns/1ps
module tb_ctlacc_gate;
    localparam int K_UND = 0, K_TRP = 1, K_RED = 2, K_C1 = 3, K_C2 = 4;

    typedef struct packed {
        logic       al;
        logic [1:0] lvl;
        logic       feat;
        logic       l3x;
        logic       l2on;
        logic       host;
        logic       uprio;
        logic       l3en;
        logic       l1g;
        logic       l2trap;
        logic       l2g;
        logic       sdd;
        logic [2:0] nv;
        logic [2:0] ek;
        logic [1:0] etl;
        logic [7:0] ecls;
        logic [7:0] rq;
    } vec_t;

    localparam int NVEC = 31;
    //                 al lvl f l3x l2on host up l3en l1g l2t l2g sdd nv  kind   tl cls    req
    localparam vec_t VEC [NVEC] = '{
        '{0,1,0,1,1,0,0,1,1,0,1,0,0, K_UND,0,8'h00, 1},  // R1 feature absent
        '{1,0,1,1,1,0,0,1,1,0,1,0,0, K_UND,0,8'h00, 1},  // R1 level 0 alias
        '{0,1,1,1,1,0,0,1,1,0,1,0,0, K_C1, 0,8'h00, 5},  // R5 baseline
        '{0,1,1,1,1,0,1,0,0,0,1,0,0, K_UND,0,8'h00, 2},  // R2 undef-first beats L1 trap
        '{0,1,1,1,1,0,0,1,0,1,1,0,0, K_TRP,1,8'h1D, 2},  // R2 L1 trap beats L2 trap
        '{0,1,1,1,1,0,0,1,1,1,1,0,0, K_TRP,2,8'h1D, 3},  // R3 L2 trap bit
        '{0,1,1,1,0,0,0,1,1,1,1,0,0, K_C1, 0,8'h00, 3},  // R3 L2 disabled
        '{0,1,1,1,1,1,0,1,1,0,0,0,0, K_TRP,2,8'h1D, 3},  // R3 host gate
        '{0,1,1,1,1,0,0,0,1,0,1,1,0, K_UND,0,8'h00, 4},  // R4 secure-debug undef
        '{0,1,1,1,1,0,0,0,1,0,1,0,0, K_TRP,3,8'h1D, 4},  // R4 trap L3
        '{0,1,1,0,1,0,0,0,1,0,1,1,0, K_C1, 0,8'h00, 4},  // R4 no L3
        '{0,1,1,1,1,0,0,1,1,0,1,0,7, K_RED,0,8'h00, 5},  // R5 redirect
        '{0,1,1,1,1,0,0,1,1,0,1,0,5, K_C1, 0,8'h00, 5},  // R5 other mode
        '{0,2,1,1,1,0,0,1,0,0,1,0,0, K_C1, 0,8'h00, 6},  // R6 no L1 check
        '{0,2,1,1,1,1,0,1,1,0,1,0,0, K_C2, 0,8'h00, 6},  // R6 host copy2
        '{0,2,1,1,0,0,0,1,1,1,1,0,0, K_TRP,2,8'h1D, 6},  // R6 trap ignores enable
        '{0,2,1,1,1,0,0,1,1,0,1,0,7, K_C1, 0,8'h00, 6},  // R6 no redirect
        '{0,3,1,1,1,0,0,0,1,0,1,1,0, K_TRP,3,8'h1D, 7},  // R7 L3 disabled
        '{0,3,1,1,1,0,1,1,0,1,0,0,7, K_C1, 0,8'h00, 7},  // R7 others ignored
        '{1,1,1,1,1,0,0,1,1,0,1,0,5, K_RED,0,8'h00, 8},  // R8 alias redirect
        '{1,1,1,1,1,0,0,1,1,0,1,0,7, K_TRP,2,8'h18, 8},  // R8 alias trap
        '{1,1,1,1,1,0,0,1,1,0,1,0,0, K_UND,0,8'h00, 8},  // R8 alias undef
        '{1,1,1,1,1,0,0,1,1,0,1,0,6, K_UND,0,8'h00, 8},  // R8 low bit clear
        '{1,2,1,1,1,0,0,1,1,0,1,0,0, K_UND,0,8'h00, 9},  // R9 not host
        '{1,2,1,1,1,1,0,1,0,0,1,0,0, K_C1, 0,8'h00, 9},  // R9 host copy1
        '{1,2,1,1,1,1,0,1,1,0,0,0,0, K_TRP,2,8'h1D, 9},  // R9 host gate
        '{1,2,1,1,1,1,0,0,1,0,1,0,0, K_TRP,3,8'h1D, 9},  // R9 L3 trap
        '{1,3,1,1,1,0,0,1,1,0,1,0,0, K_UND,0,8'h00, 9},  // R9 L3 not host
        '{1,3,1,1,1,1,0,0,1,0,1,0,0, K_TRP,3,8'h1D, 9},  // R9 L3 host trap
        '{1,3,1,1,1,1,0,1,1,0,1,0,0, K_C1, 0,8'h00, 9},  // R9 L3 host copy1
        '{1,2,1,1,1,1,1,0,1,0,1,0,0, K_UND,0,8'h00, 9}   // R9 undef-first
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_alias = 0;
    logic [1:0] cur_lvl = 0;
    logic feat_present = 0, l3_exists = 0, l2_enabled = 0, l2_host = 0;
    logic l3_undef_first = 0, l3_enable = 0, l1_gate = 0, l2_trap = 0, l2_gate = 0, l3_dbg_undef = 0;
    logic [2:0] nv_mode = 0;
    logic [63:0] wdata = 0;
    logic rsp_valid, out_undef, out_trap, out_redirect, out_copy1, out_copy2;
    logic [1:0] trap_lvl;
    logic [7:0] trap_class;
    logic [11:0] redirect_off;
    logic [63:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctlacc_gate dut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_base();
        req_alias = 0; cur_lvl = 1; feat_present = 1; l3_exists = 1; l2_enabled = 1;
        l2_host = 0; l3_undef_first = 0; l3_enable = 1; l1_gate = 1; l2_trap = 0;
        l2_gate = 1; l3_dbg_undef = 0; nv_mode = 0;
    endtask

    task automatic issue(input logic wr, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    function automatic int act_kind();
        case ({out_undef, out_trap, out_redirect, out_copy1, out_copy2})
            5'b10000: return K_UND;
            5'b01000: return K_TRP;
            5'b00100: return K_RED;
            5'b00010: return K_C1;
            5'b00001: return K_C2;
            default:  return 7;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13 reset state
        check(!rsp_valid && act_kind() == 7 && {out_undef,out_trap,out_redirect,out_copy1,out_copy2} == 0,
              "R13 idle after reset", {63'd0, rsp_valid}, 64'd0);
        set_base();
        issue(0, 0);
        check(out_copy1 && rdata == 64'd0, "R13 copy1 cleared", rdata, 64'd0);
        cur_lvl = 2; l2_host = 1;
        issue(0, 0);
        check(out_copy2 && rdata == 64'd0, "R13 copy2 cleared", rdata, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            req_alias = VEC[i].al; cur_lvl = VEC[i].lvl; feat_present = VEC[i].feat;
            l3_exists = VEC[i].l3x; l2_enabled = VEC[i].l2on; l2_host = VEC[i].host;
            l3_undef_first = VEC[i].uprio; l3_enable = VEC[i].l3en; l1_gate = VEC[i].l1g;
            l2_trap = VEC[i].l2trap; l2_gate = VEC[i].l2g; l3_dbg_undef = VEC[i].sdd;
            nv_mode = VEC[i].nv;
            issue(0, 0);
            begin
                bit ok;
                ok = rsp_valid && act_kind() == int'(VEC[i].ek);
                if (VEC[i].ek == 3'(K_TRP)) ok = ok && trap_lvl == VEC[i].etl && trap_class == VEC[i].ecls;
                if (VEC[i].ek == 3'(K_RED)) ok = ok && redirect_off == 12'h1F0;
                check(ok, $sformatf("R%0d vector %0d", VEC[i].rq, i),
                      {40'd0, 5'(act_kind()), trap_lvl, trap_class, 9'd0},
                      {40'd0, 2'b00, VEC[i].ek, VEC[i].etl, VEC[i].ecls, 9'd0});
            end
        end

        // R10 no response without a request
        @(negedge clk);
        check(!rsp_valid && act_kind() == 7 && !out_undef, "R10 idle no outcome", {63'd0, rsp_valid}, 64'd0);

        // R11 write all ones to copy1
        set_base();
        issue(1, '1);
        check(out_copy1 && rdata == 64'd0, "R12 write response rdata zero", rdata, 64'd0);
        issue(0, 0);
        check(rdata == 64'h0000_0000_8000_000F, "R11 copy1 masked", rdata, 64'h8000000F);

        // R12 write copy2 only
        cur_lvl = 2; l2_host = 1;
        issue(1, 64'hFFFF_0000_4000_0135);
        issue(0, 0);
        check(out_copy2 && rdata == 64'h5, "R11 copy2 masked", rdata, 64'h5);
        set_base();
        issue(0, 0);
        check(rdata == 64'h8000000F, "R12 copy1 untouched by copy2 write", rdata, 64'h8000000F);

        // R12 trapped write ignored
        l1_gate = 0;
        issue(1, 64'h0);
        check(out_trap && rdata == 64'd0, "R12 trapped write response", rdata, 64'd0);
        set_base();
        issue(0, 0);
        check(rdata == 64'h8000000F, "R12 trapped write ignored", rdata, 64'h8000000F);

        // R12 redirected write ignored
        nv_mode = 3'b111;
        issue(1, 64'h0);
        set_base();
        issue(0, 0);
        check(rdata == 64'h8000000F, "R12 redirected write ignored", rdata, 64'h8000000F);

        // R12 undefined write ignored, copy2 still intact
        feat_present = 0;
        issue(1, 64'h0);
        set_base(); cur_lvl = 2; l2_host = 1;
        issue(0, 0);
        check(rdata == 64'h5, "R12 undefined write ignored", rdata, 64'h5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule